// File: doc/BRIEF.md
# Hybrid Cellular Automaton Pattern Generator

This block is a one-dimensional array of cells that produces a new pseudo-random test pattern on each clock it is told to advance. It feeds the inputs of a circuit under test during built-in self-test. Each cell computes its next value from its own current value and the values of its two neighbours. A per-cell rule vector, fixed at build time, chooses one of two update rules for each cell. The first, called rule 150, takes the exclusive-OR of left, self and right. The second, called rule 90, takes the exclusive-OR of left and right only. A cell at either end of the array sees a constant 0 where its missing neighbour would be.

A mixed rule vector can give a maximal-period sequence with less correlation between adjacent bits than a shift-based LFSR gives. This helps with logic that resists random patterns. Software or a test controller starts the sequence by loading a seed. It then pulses or holds the advance input to step the array. The all-zero state maps to itself under both rules, so the block never enters it: a zero seed is replaced by the state with only the last cell set.

Top module: `ca_pattern_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets the pattern to the state with only the last cell set, which is the value 1 on the pattern bus.
- R2: Cell Xk is driven on pattern bit CELLS-1-k, so X0 is the most significant bit. The rule bit for a cell has the same index as its pattern bit: 1 selects left^self^right and 0 selects left^right. The neighbour beyond either end is constant 0.
- R3: With 4 cells and rule vector 4'b1010, each advance from 4'b0001 gives, in order, 0010, 0111, 1111, 0011, 0101, 1000, 1100, 0110, 1101, 0100, 1010, 1011, 1001, 1110, and then 0001 again.
- R4: In the 4-cell configuration, every nonzero seed returns to itself after exactly 15 advances and after no fewer.
- R5: When seedLoad is high and seedIn is nonzero, the pattern equals seedIn after the next clock edge.
- R6: When seedLoad is high and seedIn is zero, the pattern becomes the value 1 after the next clock edge.
- R7: When seedLoad and advance are both high in the same cycle, the load takes effect and the step does not.
- R8: When seedLoad and advance are both low, the pattern keeps its value across the clock edge.
- R9: Outside reset, the pattern is never all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seedLoad | input | 1 | Load seedIn into the array on this edge |
| seedIn | input | CELLS | Seed value, with the bit order of pattern |
| advance | input | 1 | Step the automaton one generation on this edge |
| pattern | output | CELLS | Current cell states, X0 in the most significant bit |

## Verification
A seed load and an advance can both be requested in the same cycle. The block must then load the seed and discard the step. The bench provokes this with a directed cycle that raises both inputs, using a nonzero seed and also a zero seed. The random phase also raises both inputs together from time to time. In each such cycle the bench judges the result by comparing the pattern with the seed, or with 1 for a zero seed, and never with the successor of the previous state.

// File: rtl/ca_pkg.sv
package ca_pkg;

  // Strobes sent from control to the cell datapath.
  typedef struct packed {
    logic load;   // take the seed this edge
    logic step;   // evolve one generation this edge
  } caStrobe_t;

endpackage

// File: rtl/ca_rule_cell.sv
module ca_rule_cell #(
  parameter bit USE_SELF = 1'b1
) (
  input  logic leftNb,
  input  logic selfVal,
  input  logic rightNb,
  output logic nextVal
);

  generate
    if (USE_SELF) begin : g_rule150
      assign nextVal = leftNb ^ selfVal ^ rightNb;
    end else begin : g_rule90
      logic unusedSelf;
      assign unusedSelf = selfVal;
      assign nextVal    = leftNb ^ rightNb;
    end
  endgenerate

endmodule

// File: rtl/ca_ctrl.sv
module ca_ctrl
  import ca_pkg::*;
(
  input  logic      seedLoad,
  input  logic      advance,
  output caStrobe_t strb
);

  always_comb begin
    strb      = '0;
    strb.load = seedLoad;
    strb.step = advance & ~seedLoad;
  end

endmodule

// File: rtl/ca_datapath.sv
module ca_datapath
  import ca_pkg::*;
#(
  parameter int             CELLS    = 4,
  parameter logic [CELLS-1:0] RULE_VEC = 4'b1010
) (
  input  logic             clk,
  input  logic             rst,
  input  caStrobe_t        strb,
  input  logic [CELLS-1:0] seedIn,
  output logic [CELLS-1:0] cellState
);

  localparam int               PAD_W     = CELLS + 2;
  localparam logic [CELLS-1:0] ONE_STATE = {{(CELLS-1){1'b0}}, 1'b1};

  logic [PAD_W-1:0] padded;
  logic [CELLS-1:0] evolved;
  logic [CELLS-1:0] seedSafe;

  // Null boundary: a zero on each side of the array.
  assign padded = {1'b0, cellState, 1'b0};

  generate
    for (genvar j = 0; j < CELLS; j++) begin : g_cell
      ca_rule_cell #(.USE_SELF(RULE_VEC[j])) i_cell (
        .leftNb (padded[j+2]),
        .selfVal(padded[j+1]),
        .rightNb(padded[j]),
        .nextVal(evolved[j])
      );
    end
  endgenerate

  assign seedSafe = (seedIn == '0) ? ONE_STATE : seedIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      cellState <= ONE_STATE;
    end else if (strb.load) begin
      cellState <= seedSafe;
    end else if (strb.step) begin
      cellState <= evolved;
    end
  end

  // R9
  state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cellState != '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.step) |=> $stable(cellState));

  // R5
  seed_take_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && seedIn != '0) |=> cellState == $past(seedIn));

  // R6
  zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && seedIn == '0) |=> cellState == ONE_STATE);

endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen
  import ca_pkg::*;
#(
  parameter int               CELLS    = 4,
  parameter logic [CELLS-1:0] RULE_VEC = 4'b1010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seedLoad,
  input  logic [CELLS-1:0] seedIn,
  input  logic             advance,
  output logic [CELLS-1:0] pattern
);

  localparam logic [CELLS-1:0] ONE_STATE = {{(CELLS-1){1'b0}}, 1'b1};

  caStrobe_t strb;

  ca_ctrl i_ctrl (
    .seedLoad(seedLoad),
    .advance (advance),
    .strb    (strb)
  );

  ca_datapath #(.CELLS(CELLS), .RULE_VEC(RULE_VEC)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .seedIn   (seedIn),
    .cellState(pattern)
  );

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && advance) |=>
      pattern == (($past(seedIn) == '0) ? ONE_STATE : $past(seedIn)));

endmodule

// File: tb/test_ca_pattern_gen.sv
module test_ca_pattern_gen;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         seedLoad;
  logic [N-1:0] seedIn;
  logic         advance;
  logic [N-1:0] pattern;

  int nVec = 0;
  int nBad = 0;
  logic [N-1:0] model;

  always #2.5 clk = ~clk;

  ca_pattern_gen #(.CELLS(N), .RULE_VEC(4'b1010)) i_ca_pattern_gen (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .seedIn(seedIn),
    .advance(advance), .pattern(pattern)
  );

  // Reference successor from R2: cell Xk on bit N-1-k, even k use the self term.
  function automatic logic [N-1:0] caNext(input logic [N-1:0] s);
    logic [N-1:0] r;
    r = '0;
    for (int k = 0; k < N; k++) begin
      logic lft, rgt, slf;
      lft = (k == 0)     ? 1'b0 : s[N-k];
      rgt = (k == N - 1) ? 1'b0 : s[N-2-k];
      slf = s[N-1-k];
      r[N-1-k] = (k % 2 == 0) ? (lft ^ slf ^ rgt) : (lft ^ rgt);
    end
    return r;
  endfunction

  function automatic logic [N-1:0] modelStep(input logic [N-1:0] s,
      input logic ld, input logic [N-1:0] sd, input logic adv);
    if (ld)  return (sd == '0) ? 4'b0001 : sd;
    if (adv) return caNext(s);
    return s;
  endfunction

  task automatic check(input string req, input logic [N-1:0] got,
                       input logic [N-1:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b", req, got, exp);
    end
  endtask

  // Drive inputs, take one edge, compare after it.
  task automatic cyc(input logic ld, input logic [N-1:0] sd,
                     input logic adv, input string req);
    seedLoad = ld; seedIn = sd; advance = adv;
    model = modelStep(model, ld, sd, adv);
    @(posedge clk); #1;
    check(req, pattern, model);
  endtask

  initial begin
    #1000000;
    nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [N-1:0] seqTab [15];
    void'($urandom(32'd4242));
    seqTab = '{4'b0001, 4'b0010, 4'b0111, 4'b1111, 4'b0011, 4'b0101, 4'b1000,
               4'b1100, 4'b0110, 4'b1101, 4'b0100, 4'b1010, 4'b1011, 4'b1001,
               4'b1110};
    rst = 1'b1; seedLoad = 1'b0; seedIn = '0; advance = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    model = 4'b0001;
    check("R1 reset state", pattern, 4'b0001);
    rst = 1'b0;

    // R3: full listed sequence from 0001
    for (int i = 1; i <= 15; i++) begin
      advance = 1'b1;
      @(posedge clk); #1;
      nVec++;
      if (pattern !== seqTab[i % 15]) begin
        nBad++;
        $display("FAIL R3 step %0d: actual %b expected %b", i, pattern, seqTab[i % 15]);
      end
    end
    advance = 1'b0;
    model = pattern;

    // R8: hold
    cyc(1'b0, 4'b1111, 1'b0, "R8 hold");
    cyc(1'b0, 4'b0000, 1'b0, "R8 hold");

    // R5 / R6 / R7 directed
    cyc(1'b1, 4'b1001, 1'b0, "R5 load");
    cyc(1'b1, 4'b0000, 1'b0, "R6 zero seed");
    cyc(1'b0, 4'b0000, 1'b1, "R2 step");
    cyc(1'b1, 4'b0110, 1'b1, "R7 load beats advance");
    cyc(1'b1, 4'b0000, 1'b1, "R7 zero load beats advance");

    // R4: period exactly 15 from every nonzero seed
    for (int sd = 1; sd < 16; sd++) begin
      int per;
      cyc(1'b1, sd[N-1:0], 1'b0, "R5 seed for period");
      per = 0;
      seedLoad = 1'b0; advance = 1'b1;
      do begin
        @(posedge clk); #1;
        per++;
      end while (pattern !== sd[N-1:0] && per < 20);
      advance = 1'b0;
      nVec++;
      if (per != 15) begin
        nBad++;
        $display("FAIL R4 seed %b: actual period %0d expected 15", sd[N-1:0], per);
      end
      model = pattern;
    end

    // Random mix against the reference, R2 R5 R6 R7 R8 R9
    for (int i = 0; i < 400; i++) begin
      logic ld, adv;
      logic [N-1:0] sd;
      ld  = ($urandom % 6) == 0;
      adv = ($urandom % 2) == 0;
      sd  = (($urandom % 5) == 0) ? '0 : N'($urandom);
      cyc(ld, sd, adv, "R2/R5/R6/R7/R8 random");
      nVec++;
      if (pattern === '0) begin
        nBad++;
        $display("FAIL R9: actual %b expected nonzero", pattern);
      end
    end

    // Reset mid-run returns to start (R1)
    rst = 1'b1; advance = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0; advance = 1'b0; model = 4'b0001;
    check("R1 reset mid-run", pattern, 4'b0001);

    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule